// File: doc/BRIEF.md
# SIMD Container Element Reversal Unit

This block is the execute slice for one vector permute instruction. It takes a 32-bit instruction word and a 128-bit source value, both qualified by a valid strobe. The operand is split into containers of 16, 32 or 64 bits, and inside each container the elements (8, 16 or 32 bits wide) are written back in reverse order. The bits inside each element keep their order. The instruction word selects the container size, the element size and whether 64 or 128 bits are processed.

Encodings that are not legal raise an undefined-instruction flag and give a zero result. An encoding is not legal when a fixed opcode bit is wrong, when a selector value is reserved, or when the element would be at least as wide as its container. The destination register index is passed through to the output. The result appears one clock after the input, and the latency does not depend on the operand data.

Top module: `simd_ctr_rev`

## Requirements
- R1: The fixed opcode fields must hold these values: bit31 = 0, bits28:24 = 01110, bits21:17 = 10000, bits16:13 = 0000 and bits11:10 = 10. If any one of them differs, out_undef is 1.
- R2: The container width is chosen by the pair {bit12, bit29}. The value 00 selects 64 bits, 01 selects 32 bits and 10 selects 16 bits. The value 11 is undefined.
- R3: The element width is chosen by bits23:22. The value 00 selects 8 bits, 01 selects 16 bits and 10 selects 32 bits. The value 11 is undefined.
- R4: A combination whose container width is less than or equal to its element width is undefined. This covers 32/32, 16/16 and 16/32.
- R5: For a legal instruction, element k of each container is moved to position (n-1-k), where n is the number of elements per container. The bit order inside each element is kept.
- R6: Bit30 is the width select. When it is 0, only the low 64 bits are processed and out_result[127:64] is zero. When it is 1, all 128 bits are processed.
- R7: When out_undef is 1, out_result is all zeros.
- R8: out_valid is in_valid delayed by exactly one clock, whatever the operand data. Each output beat carries instruction bits 4:0 on out_rd.
- R9: While rst_n is low at a clock edge, out_valid, out_result and out_undef are cleared to 0. Reset is synchronous.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input beat qualifier |
| in_insn | input | 32 | Instruction word |
| in_opnd | input | 128 | Source operand |
| out_valid | output | 1 | Result qualifier, one clock after in_valid |
| out_result | output | 128 | Permuted value, or zero when undefined |
| out_rd | output | 5 | Destination register index from bits 4:0 |
| out_undef | output | 1 | Undefined-instruction flag |

## Verification
The bench builds the block with its default lane width of 64 bits, which gives a 128-bit datapath. With that width all six legal container/element pairings can be reached, each with both settings of the width-select bit, so upper-half zeroing and full-width reversal are both exercised. Every legal pairing is run with random operands and compared against a reference loop over containers and elements. Directed encodings cover each fixed-field mismatch, each reserved selector and each pairing where the element fills or exceeds its container.

// File: rtl/simd_rev_pkg.sv
// Package: shared types and constant helpers for the container reversal unit.
// Assumes: byte-granular elements; containers and elements are powers of two.
package simd_rev_pkg;

    // Legal container/element pairings, one code per permutation variant
    typedef enum logic [2:0] {
        RM_C64_E8  = 3'd0,
        RM_C64_E16 = 3'd1,
        RM_C64_E32 = 3'd2,
        RM_C32_E8  = 3'd3,
        RM_C32_E16 = 3'd4,
        RM_C16_E8  = 3'd5
    } rev_mode_e;

    localparam int NUM_MODES = 6;

    // Decoded view of one instruction word
    typedef struct packed {
        logic      legal;
        logic      wide;
        rev_mode_e mode;
        logic [4:0] rd;
    } rev_dec_t;

    // log2 of the container width in bytes for a mode index
    function automatic int mode_cb_log(input int m);
        case (m)
            0, 1, 2: return 3;
            3, 4:    return 2;
            default: return 1;
        endcase
    endfunction

    // log2 of the element width in bytes for a mode index
    function automatic int mode_eb_log(input int m);
        case (m)
            0, 3, 5: return 0;
            1, 4:    return 1;
            default: return 2;
        endcase
    endfunction

endpackage

// File: rtl/rev_decode.sv
// Module: rev_decode
// Checks the fixed opcode fields and derives the container and element sizes,
// the width select and the destination index from one instruction word.
// Assumes: the layout stated in the brief; the source register field is not used here.
module rev_decode
    import simd_rev_pkg::*;
#(
    parameter int INSN_W = 32,
    parameter int IDX_W  = 5
) (
    input  logic [INSN_W-1:0] insn,
    output rev_dec_t          dec
);

    localparam logic [4:0] OPC_HI  = 5'b01110;
    localparam logic [4:0] OPC_MID = 5'b10000;
    localparam logic [3:0] OPC_LO  = 4'b0000;
    localparam logic [1:0] OPC_TL  = 2'b10;

    logic       fixed_ok;
    logic [1:0] csel;
    logic [1:0] esel;
    logic [1:0] cb_log;
    logic       csel_ok;
    logic       pair_ok;
    rev_mode_e  mode;
    logic       rn_unused;

    // Source register field is carried by the instruction but not needed
    assign rn_unused = ^insn[9:5];

    // Compare every fixed opcode field
    always_comb begin
        fixed_ok = (insn[31] == 1'b0) &&
                   (insn[28:24] == OPC_HI) &&
                   (insn[21:17] == OPC_MID) &&
                   (insn[16:13] == OPC_LO) &&
                   (insn[11:10] == OPC_TL);
    end

    // Container selector: o0 is the upper bit, U the lower
    always_comb begin
        csel    = {insn[12], insn[29]};
        esel    = insn[23:22];
        csel_ok = (csel != 2'b11);
        case (csel)
            2'b00:   cb_log = 2'd3;
            2'b01:   cb_log = 2'd2;
            default: cb_log = 2'd1;
        endcase
    end

    // Element must be strictly narrower than its container
    always_comb begin
        pair_ok = csel_ok && (esel != 2'b11) && ({1'b0, esel} < {1'b0, cb_log});
    end

    // Map the legal size pairing onto its permutation variant
    always_comb begin
        mode = RM_C64_E8;
        case ({cb_log, esel})
            {2'd3, 2'd0}: mode = RM_C64_E8;
            {2'd3, 2'd1}: mode = RM_C64_E16;
            {2'd3, 2'd2}: mode = RM_C64_E32;
            {2'd2, 2'd0}: mode = RM_C32_E8;
            {2'd2, 2'd1}: mode = RM_C32_E16;
            {2'd1, 2'd0}: mode = RM_C16_E8;
            default:      mode = RM_C64_E8;
        endcase
    end

    // Assemble the decoded record
    always_comb begin
        dec.legal = fixed_ok && pair_ok;
        dec.wide  = insn[30];
        dec.mode  = mode;
        dec.rd    = insn[IDX_W-1:0];
    end

endmodule

// File: rtl/rev_permute.sv
// Module: rev_permute
// Builds every legal reversal pattern as fixed wiring and selects one by mode.
// The upper lane is zeroed when only the low lane is processed.
// Assumes: DATA_W is two lanes of LANE_W bits; the selection logic depth does not depend on the data.
module rev_permute
    import simd_rev_pkg::*;
#(
    parameter int LANE_W = 64
) (
    input  logic [2*LANE_W-1:0] opnd,
    input  rev_mode_e           mode,
    input  logic                wide,
    output logic [2*LANE_W-1:0] res
);

    localparam int DATA_W = 2 * LANE_W;
    localparam int NBYTES = DATA_W / 8;

    logic [NUM_MODES-1:0][DATA_W-1:0] perm;

    // One wiring pattern per mode, one byte route per output byte
    for (genvar m = 0; m < NUM_MODES; m++) begin : g_mode
        localparam int CB = 1 << mode_cb_log(m);
        localparam int EB = 1 << mode_eb_log(m);
        localparam int NE = CB / EB;
        for (genvar b = 0; b < NBYTES; b++) begin : g_byte
            localparam int OFF  = b % CB;
            localparam int BASE = b - OFF;
            localparam int K    = OFF / EB;
            localparam int J    = OFF % EB;
            localparam int SRC  = BASE + (NE - 1 - K) * EB + J;
            assign perm[m][b*8 +: 8] = opnd[SRC*8 +: 8];
        end
    end

    // Pick the active pattern and clear the upper lane for narrow operations
    always_comb begin
        res = '0;
        for (int m = 0; m < NUM_MODES; m++) begin
            if (int'(mode) == m) begin
                res = perm[m];
            end
        end
        if (!wide) begin
            res[DATA_W-1:LANE_W] = '0;
        end
    end

endmodule

// File: rtl/rev_outstage.sv
// Module: rev_outstage
// Single register stage on the result path; forces a zero result for undefined encodings.
// Assumes: synchronous active-low reset; data registers load only on valid beats.
module rev_outstage #(
    parameter int DATA_W = 128,
    parameter int IDX_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              v_in,
    input  logic              legal_in,
    input  logic [DATA_W-1:0] res_in,
    input  logic [IDX_W-1:0]  rd_in,
    output logic              v_out,
    output logic [DATA_W-1:0] res_out,
    output logic [IDX_W-1:0]  rd_out,
    output logic              undef_out
);

    // Valid pipe: follows the input strobe by one clock
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v_out <= 1'b0;
        end else begin
            v_out <= v_in;
        end
    end

    // Payload register: captured on each accepted beat
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_out   <= '0;
            rd_out    <= '0;
            undef_out <= 1'b0;
        end else if (v_in) begin
            res_out   <= legal_in ? res_in : '0;
            rd_out    <= rd_in;
            undef_out <= !legal_in;
        end
    end

endmodule

// File: rtl/simd_ctr_rev.sv
// Module: simd_ctr_rev (top)
// Decodes one reversal instruction, permutes the operand and registers the result.
// Assumes: one beat per clock may be accepted; latency is one clock for every encoding.
module simd_ctr_rev
    import simd_rev_pkg::*;
#(
    parameter int LANE_W = 64,
    parameter int INSN_W = 32,
    parameter int IDX_W  = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [INSN_W-1:0]   in_insn,
    input  logic [2*LANE_W-1:0] in_opnd,
    output logic                out_valid,
    output logic [2*LANE_W-1:0] out_result,
    output logic [IDX_W-1:0]    out_rd,
    output logic                out_undef
);

    localparam int DATA_W = 2 * LANE_W;

    rev_dec_t          dec;
    logic [DATA_W-1:0] perm_res;

    // Field decode
    rev_decode #(
        .INSN_W (INSN_W),
        .IDX_W  (IDX_W)
    ) u_decode (
        .insn (in_insn),
        .dec  (dec)
    );

    // Byte routing network
    rev_permute #(
        .LANE_W (LANE_W)
    ) u_permute (
        .opnd (in_opnd),
        .mode (dec.mode),
        .wide (dec.wide),
        .res  (perm_res)
    );

    // Output register stage
    rev_outstage #(
        .DATA_W (DATA_W),
        .IDX_W  (IDX_W)
    ) u_outstage (
        .clk       (clk),
        .rst_n     (rst_n),
        .v_in      (in_valid),
        .legal_in  (dec.legal),
        .res_in    (perm_res),
        .rd_in     (dec.rd),
        .v_out     (out_valid),
        .res_out   (out_result),
        .rd_out    (out_rd),
        .undef_out (out_undef)
    );

endmodule

// File: rtl/simd_ctr_rev_chk.sv
// Module: simd_ctr_rev_chk
// Port-level temporal checks for simd_ctr_rev, attached through bind.
// Assumes: default widths (128-bit data, 32-bit instruction, 5-bit index).
module simd_ctr_rev_chk (
    input logic         clk,
    input logic         rst_n,
    input logic         in_valid,
    input logic [31:0]  in_insn,
    input logic         out_valid,
    input logic [127:0] out_result,
    input logic [4:0]   out_rd,
    input logic         out_undef
);

    AST_BAD_TOP_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_insn[31]) |=> out_undef); // R1

    AST_BAD_CSEL: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_insn[12] && in_insn[29]) |=> out_undef); // R2

    AST_BAD_ESIZE: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_insn[23:22] == 2'b11) |=> out_undef); // R3

    AST_ELEM_FILLS_CTR: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_insn[12] && !in_insn[29] && in_insn[23:22] != 2'b00) |=> out_undef); // R4

    AST_NARROW_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_insn[30]) |=> (out_result[127:64] == 64'd0)); // R6

    AST_UNDEF_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_undef) |-> (out_result == 128'd0)); // R7

    AST_VALID_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R8

    AST_VALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid); // R8

    AST_RD_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (out_rd == $past(in_insn[4:0]))); // R8

    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && !out_undef && out_result == 128'd0)); // R9

endmodule

bind simd_ctr_rev simd_ctr_rev_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_insn    (in_insn),
    .out_valid  (out_valid),
    .out_result (out_result),
    .out_rd     (out_rd),
    .out_undef  (out_undef)
);

// File: tb/simd_ctr_rev_tb.sv
// Scoreboard bench: the driver queues reference results, the monitor pops and compares.
module simd_ctr_rev_tb;

    typedef struct {
        logic [127:0] res;
        logic [4:0]   rd;
        logic         und;
        string        tag;
    } exp_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [31:0]  in_insn = '0;
    logic [127:0] in_opnd = '0;
    logic         out_valid;
    logic [127:0] out_result;
    logic [4:0]   out_rd;
    logic         out_undef;

    int   checks = 0;
    int   errors = 0;
    exp_t q[$];
    logic exp_v = 1'b0;
    logic mon_on = 1'b0;
    int   cyc = 0;

    always #10 clk = ~clk;

    simd_ctr_rev u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_insn    (in_insn),
        .in_opnd    (in_opnd),
        .out_valid  (out_valid),
        .out_result (out_result),
        .out_rd     (out_rd),
        .out_undef  (out_undef)
    );

    // Build a well-formed instruction word from its fields
    function automatic logic [31:0] mk(input logic q_b, input logic u_b, input logic [1:0] sz,
                                       input logic o0, input logic [4:0] rn, input logic [4:0] rd);
        return {1'b0, q_b, u_b, 5'b01110, sz, 5'b10000, 4'b0000, o0, 2'b10, rn, rd};
    endfunction

    // Reference loop over containers and elements, written from the requirements
    function automatic void ref_model(input logic [31:0] insn, input logic [127:0] op,
                                      output logic [127:0] res, output logic und);
        int  csz, esz, dw, n;
        logic fixed_ok;
        fixed_ok = (insn[31] == 1'b0) && (insn[28:24] == 5'b01110) && (insn[21:17] == 5'b10000)
                   && (insn[16:13] == 4'b0000) && (insn[11:10] == 2'b10);
        case ({insn[12], insn[29]})
            2'b00:   csz = 64;
            2'b01:   csz = 32;
            2'b10:   csz = 16;
            default: csz = 0;
        endcase
        esz = 8 << insn[23:22];
        und = !fixed_ok || (csz == 0) || (csz <= esz);
        res = '0;
        if (!und) begin
            dw = insn[30] ? 128 : 64;
            n  = csz / esz;
            for (int c = 0; c < dw / csz; c++)
                for (int k = 0; k < n; k++)
                    for (int i = 0; i < esz; i++)
                        res[c*csz + (n-1-k)*esz + i] = op[c*csz + k*esz + i];
        end
    endfunction

    task automatic check1(input string tag, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Driver: present one beat and queue its expected outcome
    task automatic send(input logic [31:0] insn, input logic [127:0] op, input string tag);
        exp_t e;
        @(negedge clk);
        in_valid = 1'b1;
        in_insn  = insn;
        in_opnd  = op;
        ref_model(insn, op, e.res, e.und);
        e.rd  = insn[4:0];
        e.tag = tag;
        q.push_back(e);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_opnd  = {$urandom, $urandom, $urandom, $urandom};
        end
    endtask

    function automatic logic [127:0] rnd128();
        return {$urandom, $urandom, $urandom, $urandom};
    endfunction

    // Expected valid shadow: input strobe seen one edge earlier
    always @(posedge clk) begin
        exp_v <= rst_n ? in_valid : 1'b0;
        cyc   <= cyc + 1;
    end

    // Monitor: compare each result beat with the head of the queue
    always @(negedge clk) begin
        if (mon_on) begin
            check1("R8 valid timing", {127'd0, out_valid}, {127'd0, exp_v});
            if (out_valid) begin
                if (q.size() == 0) begin
                    checks++;
                    errors++;
                    $display("FAIL R8 unexpected beat actual=1 expected=0");
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    check1({e.tag, " result"}, out_result, e.res);
                    check1({e.tag, " undef"}, {127'd0, out_undef}, {127'd0, e.und});
                    check1("R8 rd", {123'd0, out_rd}, {123'd0, e.rd});
                end
            end
        end
    end

    // Watchdog
    initial begin
        wait (cyc > 150000);
        checks++;
        errors++;
        $display("FAIL watchdog actual=%0d expected<150000", cyc);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] base;
        // R9: reset dominates a valid input
        in_valid = 1'b1;
        in_insn  = mk(1'b1, 1'b0, 2'b00, 1'b0, 5'd1, 5'd7);
        in_opnd  = rnd128();
        repeat (3) @(negedge clk);
        check1("R9 reset valid", {127'd0, out_valid}, 128'd0);
        check1("R9 reset result", out_result, 128'd0);
        check1("R9 reset undef", {127'd0, out_undef}, 128'd0);
        in_valid = 1'b0;
        rst_n    = 1'b1;
        @(negedge clk);
        mon_on = 1'b1;

        // R5: directed byte-ramp operand, 64-bit containers of bytes, full width
        send(mk(1'b1, 1'b0, 2'b00, 1'b0, 5'd2, 5'd3), 128'h0f0e0d0c0b0a09080706050403020100, "R5 ramp");
        send(mk(1'b0, 1'b0, 2'b00, 1'b0, 5'd2, 5'd4), 128'h0f0e0d0c0b0a09080706050403020100, "R6 ramp narrow");
        idle(2);

        // R2 R3 R5 R6: every legal pairing, both widths, random operands
        for (int rep = 0; rep < 40; rep++) begin
            for (int cs = 0; cs < 3; cs++) begin
                for (int es = 0; es < 3; es++) begin
                    for (int qb = 0; qb < 2; qb++) begin
                        logic o0, ub;
                        o0 = (cs == 2);
                        ub = (cs == 1);
                        if ((64 >> cs) > (8 << es)) begin
                            send(mk(qb[0], ub, es[1:0], o0, 5'($urandom), 5'($urandom)), rnd128(),
                                 qb ? "R5 legal" : "R6 legal narrow");
                            if ((rep % 7) == 3) idle(1);
                        end
                    end
                end
            end
        end

        // R4: element fills or exceeds container
        send(mk(1'b1, 1'b1, 2'b10, 1'b0, 5'd0, 5'd9), rnd128(), "R4 c32e32");
        send(mk(1'b1, 1'b0, 2'b01, 1'b1, 5'd0, 5'd10), rnd128(), "R4 c16e16");
        send(mk(1'b0, 1'b0, 2'b10, 1'b1, 5'd0, 5'd11), rnd128(), "R4 c16e32");
        // R3: reserved element size
        send(mk(1'b1, 1'b0, 2'b11, 1'b0, 5'd0, 5'd12), rnd128(), "R3 size3");
        // R2: reserved container selector
        send(mk(1'b1, 1'b1, 2'b00, 1'b1, 5'd0, 5'd13), rnd128(), "R2 csel3");
        idle(1);

        // R1 R7: flip each fixed opcode bit on an otherwise legal word
        base = mk(1'b1, 1'b0, 2'b00, 1'b0, 5'd5, 5'd21);
        for (int b = 10; b < 32; b++) begin
            if (b == 31 || (b >= 24 && b <= 28) || (b >= 13 && b <= 21) || b == 10 || b == 11) begin
                logic [31:0] w;
                w = base;
                w[b] = ~w[b];
                send(w, rnd128(), "R1 opcode");
            end
        end
        // R7: undefined result is zero even with all-ones operand
        send(mk(1'b1, 1'b1, 2'b11, 1'b1, 5'd0, 5'd30), {128{1'b1}}, "R7 zero");
        idle(3);

        check1("R8 queue drained", {96'd0, 32'(q.size())}, 128'd0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule